// File: doc/BRIEF.md
# Byte-Lane Bus RAM with Selectable Data Byte Order

This block is a 32-bit on-chip RAM that sits as a slave on an AHB-Lite style bus. It accepts byte, halfword and word writes, updating only the bytes a transfer addresses. Each write takes two phases. The address phase supplies the address, the size and the direction. The data phase that follows supplies the data, and the write is committed there. Reads complete with zero wait states.

A parameter fixes the byte order that data accesses use, either little-endian or big-endian. Opcode fetches, marked by the bus protection signal, always use little-endian lane mapping. Memory holds bytes in address order, so the byte order only changes which bus lane a given address byte travels on.

The array is a plain behavioural memory with one synchronous read port and one write port with per-byte enables. Tools can infer it as block RAM, and it can later be exchanged for a compiled macro. A read placed directly after a write to the same word sees the new bytes through a forwarding path, with no stall.

Top module: `lane_ram`

## Requirements
- R1: After reset, hrdata is 0, hreadyout is 1 and hresp is 0, and hrdata keeps the value 0 until the first read.
- R2: A word write (hsize=2, haddr[1:0]=0) followed later by a word read of the same address returns the written word. The read data is valid in the cycle after the read's address phase.
- R3: A byte write (hsize=0) changes only the addressed byte. With little-endian mapping, address offset k (haddr[1:0]=k) uses bus bits [8k+7:8k].
- R4: A halfword write (hsize=1, haddr[0]=0) changes only its two bytes. With little-endian mapping, offset 0 uses bits [15:0] and offset 2 uses bits [31:16].
- R5: With BIG_ENDIAN=1, a data access (hprot[0]=1) to byte offset k uses bus bits [31-8k:24-8k]. A halfword at offset 0 uses [31:16], and a word carries address byte 0 on [31:24].
- R6: An opcode fetch (hprot[0]=0) always uses little-endian lane mapping, whatever BIG_ENDIAN is set to.
- R7: A read whose address phase falls in the data phase of a write to the same word returns the newly written bytes merged with the unchanged ones, and hreadyout stays 1.
- R8: A halfword write with haddr[0]=1, or a word write with haddr[1:0]!=0, changes no byte of memory.
- R9: hreadyout is always 1 and hresp is always 0 (OKAY).
- R10: An address phase is taken only when hsel=1, htrans[1]=1 (NONSEQ or SEQ) and hready=1. Any other transfer writes nothing and leaves hrdata unchanged.
- R11: hrdata changes only in the cycle after an accepted read address phase, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte address |
| htrans | input | 2 | Transfer type; bit 1 marks an active transfer |
| hwrite | input | 1 | 1 for a write |
| hsize | input | 3 | 0 byte, 1 halfword, 2 word |
| hprot | input | 4 | Protection; bit 0 is 0 for an opcode fetch |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready | input | 1 | Bus ready; the previous transfer has completed |
| hreadyout | output | 1 | Slave ready, always 1 |
| hresp | output | 1 | Response, always 0 (OKAY) |
| hrdata | output | 32 | Read data, valid in the read data phase |

## Verification
The case to watch is a write data phase that lands in the same cycle as the address phase of a read to the same word. In that cycle the array commits the write on the clock edge where it also samples the read, so the read would see stale bytes unless the forwarding merge steps in. The bench provokes this with back-to-back write-then-read pairs using word, byte and halfword writes, including two writes in a row before the read. It runs the same stimulus on a little-endian instance and a big-endian instance. The byte model in the bench predicts the merged word for each instance on every clock, and a mismatch in any lane is reported.

// File: rtl/lane_ram.sv
module lane_ram #(
  parameter int ADDR_W     = 12,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [3:0]        hprot,
  input  logic [31:0]       hwdata,
  input  logic              hready,
  output logic              hreadyout,
  output logic              hresp,
  output logic [31:0]       hrdata
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int DEPTH = 1 << IDX_W;

  function automatic logic [31:0] flip(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  logic [31:0] mem [DEPTH];

  logic             take, take_rd, take_wr, swap_now;
  logic [IDX_W-1:0] idx;
  logic [3:0]       be_now;

  logic             wr_en, wr_swap;
  logic [IDX_W-1:0] wr_idx;
  logic [3:0]       wr_be;
  logic [31:0]      wr_dat;

  logic [31:0]      rd_q, fwd_dat;
  logic [3:0]       fwd_be;
  logic             rd_swap;
  logic [31:0]      merged;
  logic             unused_bits;

  assign unused_bits = ^{hprot[3:1], htrans[0]};

  assign take     = hsel & htrans[1] & hready;
  assign take_rd  = take & ~hwrite;
  assign take_wr  = take & hwrite;
  assign idx      = haddr[ADDR_W-1:2];
  assign swap_now = BIG_ENDIAN & hprot[0];

  always_comb begin
    be_now = 4'b0000;
    case (hsize)
      3'd0: be_now = 4'b0001 << haddr[1:0];
      3'd1: if (!haddr[0]) be_now = haddr[1] ? 4'b1100 : 4'b0011;
      3'd2: if (haddr[1:0] == 2'b00) be_now = 4'b1111;
      default: be_now = 4'b0000;
    endcase
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      wr_en   <= 1'b0;
      wr_swap <= 1'b0;
      wr_idx  <= '0;
      wr_be   <= '0;
    end else begin
      wr_en <= take_wr && (be_now != 4'b0000);
      if (take_wr) begin
        wr_swap <= swap_now;
        wr_idx  <= idx;
        wr_be   <= be_now;
      end
    end
  end

  assign wr_dat = wr_swap ? flip(hwdata) : hwdata;

  always_ff @(posedge hclk) begin
    if (wr_en)
      for (int i = 0; i < 4; i++)
        if (wr_be[i]) mem[wr_idx][8*i +: 8] <= wr_dat[8*i +: 8];
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      rd_q    <= '0;
      fwd_dat <= '0;
      fwd_be  <= '0;
      rd_swap <= 1'b0;
    end else if (take_rd) begin
      rd_q    <= mem[idx];
      rd_swap <= swap_now;
      fwd_dat <= wr_dat;
      fwd_be  <= (wr_en && wr_idx == idx) ? wr_be : 4'b0000;
    end
  end

  always_comb
    for (int i = 0; i < 4; i++)
      merged[8*i +: 8] = fwd_be[i] ? fwd_dat[8*i +: 8] : rd_q[8*i +: 8];

  assign hrdata    = rd_swap ? flip(merged) : merged;
  assign hreadyout = 1'b1;
  assign hresp     = 1'b0;
endmodule

// File: rtl/lane_ram_chk.sv
module lane_ram_chk #(
  parameter int ADDR_W = 12
) (
  input logic              hclk,
  input logic              hresetn,
  input logic              hsel,
  input logic [ADDR_W-1:0] haddr,
  input logic [1:0]        htrans,
  input logic              hwrite,
  input logic [2:0]        hsize,
  input logic [3:0]        hprot,
  input logic [31:0]       hwdata,
  input logic              hready,
  input logic              hreadyout,
  input logic              hresp,
  input logic [31:0]       hrdata
);
  AST_READY_HIGH: assert property (@(posedge hclk) disable iff (!hresetn)
    hreadyout == 1'b1); // R9

  AST_RESP_OKAY: assert property (@(posedge hclk) disable iff (!hresetn)
    hresp == 1'b0); // R9

  AST_RDATA_HOLDS: assert property (@(posedge hclk) disable iff (!hresetn)
    !(hsel && htrans[1] && hready && !hwrite) |=> $stable(hrdata)); // R11

  AST_WORD_FORWARD: assert property (@(posedge hclk) disable iff (!hresetn)
    (hsel && htrans[1] && hready && hwrite && hsize == 3'd2 && haddr[1:0] == 2'b00 && hprot[0])
    ##1 (hsel && htrans[1] && hready && !hwrite && hprot[0] && haddr == $past(haddr))
    |=> hrdata == $past(hwdata)); // R7
endmodule

bind lane_ram lane_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
  .hwrite(hwrite), .hsize(hsize), .hprot(hprot), .hwdata(hwdata), .hready(hready),
  .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata)
);

// File: tb/lane_ram_test.sv
module lane_ram_test;
  localparam int AW = 12;

  logic          hclk = 1'b0, hresetn = 1'b0;
  logic          hsel = 1'b0, hwrite = 1'b0, hready = 1'b1;
  logic [AW-1:0] haddr = '0;
  logic [1:0]    htrans = 2'b00;
  logic [2:0]    hsize = 3'd0;
  logic [3:0]    hprot = 4'b0011;
  logic [31:0]   hwdata = '0;
  logic          rdy_le, rsp_le, rdy_be, rsp_be;
  logic [31:0]   rd_le, rd_be;

  always #10 hclk = ~hclk;

  lane_ram #(.ADDR_W(AW), .BIG_ENDIAN(1'b0)) uut (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hprot(hprot), .hwdata(hwdata), .hready(hready),
    .hreadyout(rdy_le), .hresp(rsp_le), .hrdata(rd_le));

  lane_ram #(.ADDR_W(AW), .BIG_ENDIAN(1'b1)) uut_be (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hprot(hprot), .hwdata(hwdata), .hready(hready),
    .hreadyout(rdy_be), .hresp(rsp_be), .hrdata(rd_be));

  logic [7:0] m_le [1 << AW];
  logic [7:0] m_be [1 << AW];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  bit          p_rd = 0, p_wr = 0, p_fetch = 0;
  logic [2:0]  p_sz = 0;
  logic [AW-1:0] p_a = 0;
  logic [31:0] p_wd = 0, last_le = 0, last_be = 0;
  string       p_tag = "";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lane_of(input bit big, input bit fetch, input int off);
    return (big && !fetch) ? 3 - off : off;
  endfunction

  function automatic logic [31:0] expect_rd(input bit big, input bit fetch, input logic [AW-1:0] a);
    logic [31:0] w;
    int base = int'(a) & ~3;
    for (int off = 0; off < 4; off++)
      w[8*lane_of(big, fetch, off) +: 8] = big ? m_be[base + off] : m_le[base + off];
    return w;
  endfunction

  task automatic model_wr(input bit fetch, input logic [2:0] sz, input logic [AW-1:0] a, input logic [31:0] wd);
    int n;
    bit ok;
    ok = (sz == 0) || (sz == 1 && a[0] == 1'b0) || (sz == 2 && a[1:0] == 2'b00);
    if (!ok) return;
    n = 1 << sz;
    for (int k = 0; k < n; k++) begin
      int b = int'(a) + k;
      m_le[b] = wd[8*lane_of(0, fetch, b & 3) +: 8];
      m_be[b] = wd[8*lane_of(1, fetch, b & 3) +: 8];
    end
  endtask

  // one bus cycle: called just after a falling edge
  task automatic step(input bit sel, input bit act, input bit wr, input logic [2:0] sz,
                      input logic [AW-1:0] a, input bit fetch, input logic [31:0] wd,
                      input bit rdy, input string tag);
    chk("R9 hreadyout le", {31'b0, rdy_le}, 32'd1);
    chk("R9 hresp be", {31'b0, rsp_be}, 32'd0);
    if (p_rd) begin
      last_le = expect_rd(0, p_fetch, p_a);
      last_be = expect_rd(1, p_fetch, p_a);
    end
    chk({p_tag, " le"}, rd_le, last_le);
    chk({p_tag, " be"}, rd_be, last_be);
    if (p_wr) begin
      hwdata = p_wd;
      model_wr(p_fetch, p_sz, p_a, p_wd);
    end else hwdata = 32'hFFFF_FFFF;
    hsel = sel; htrans = act ? 2'b10 : 2'b00; hwrite = wr; hsize = sz;
    haddr = a; hprot = fetch ? 4'b0010 : 4'b0011; hready = rdy;
    p_rd = sel && act && rdy && !wr;
    p_wr = sel && act && rdy && wr;
    p_sz = sz; p_a = a; p_fetch = fetch; p_wd = wd;
    p_tag = p_rd ? tag : "R11 hold";
    @(negedge hclk);
  endtask

  task automatic wr(input logic [2:0] sz, input logic [AW-1:0] a, input logic [31:0] wd, input string tag);
    step(1, 1, 1, sz, a, 0, wd, 1, tag);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1, 1, 0, 3'd2, a, 0, 0, 1, tag);
  endtask
  task automatic fetch_rd(input logic [AW-1:0] a, input string tag);
    step(1, 1, 0, 3'd2, a, 1, 0, 1, tag);
  endtask
  task automatic idle();
    step(0, 0, 0, 3'd0, '0, 0, 0, 1, "R11 idle");
  endtask

  initial begin
    repeat (3) @(negedge hclk);
    hresetn = 1'b1;
    @(negedge hclk);
    // R1 reset values checked by the first steps
    idle(); idle();
    // R2 word writes then reads
    wr(3'd2, 12'h000, 32'h0102_0304, "R2");
    wr(3'd2, 12'h004, 32'hCAFE_F00D, "R2");
    wr(3'd2, 12'h100, 32'h1122_3344, "R2");
    wr(3'd2, 12'h200, 32'h5566_7788, "R2");
    wr(3'd2, 12'h300, 32'h99AA_BBCC, "R2");
    idle();
    rd(12'h000, "R2 word read"); rd(12'h004, "R2 word read");
    // R3 byte writes, each lane
    for (int k = 0; k < 4; k++) wr(3'd0, 12'h100 + k[AW-1:0], 32'hA1B2_C3D4 + k, "R3");
    idle();
    rd(12'h100, "R3 byte lanes");
    wr(3'd0, 12'h001, 32'h0000_EE00, "R3"); idle();
    rd(12'h000, "R3 single byte");
    // R4 halfwords
    wr(3'd1, 12'h202, 32'hBEEF_DEAD, "R4"); idle();
    rd(12'h200, "R4 upper half");
    wr(3'd1, 12'h200, 32'h1357_2468, "R4"); idle();
    rd(12'h200, "R4 lower half");
    // R5 big-endian data, R6 opcode fetch
    rd(12'h004, "R5 data word order");
    fetch_rd(12'h004, "R6 fetch word order");
    fetch_rd(12'h200, "R6 fetch after halfwords");
    step(1, 1, 1, 3'd0, 12'h006, 1, 32'h7766_5544, 1, "R6"); idle();
    rd(12'h004, "R6 fetch byte write");
    step(1, 1, 1, 3'd1, 12'h004, 1, 32'h0A0B_0C0D, 1, "R6"); idle();
    fetch_rd(12'h004, "R6 fetch half write");
    // R7 forwarding
    wr(3'd2, 12'h300, 32'hDEAD_BEEF, "R7");
    rd(12'h300, "R7 word forward");
    wr(3'd0, 12'h301, 32'h1234_5678, "R7");
    rd(12'h300, "R7 byte forward");
    wr(3'd1, 12'h302, 32'h4321_8765, "R7");
    fetch_rd(12'h300, "R7 half forward fetch");
    wr(3'd0, 12'h300, 32'h0F0F_0F0F, "R7");
    wr(3'd0, 12'h303, 32'hF0F0_F0F0, "R7");
    rd(12'h300, "R7 two writes then read");
    wr(3'd2, 12'h004, 32'h2468_ACE0, "R7");
    rd(12'h000, "R7 other word no forward");
    rd(12'h004, "R7 later read");
    // R8 unaligned writes ignored
    wr(3'd1, 12'h101, 32'hFFFF_FFFF, "R8");
    wr(3'd2, 12'h102, 32'hFFFF_FFFF, "R8");
    wr(3'd2, 12'h0FF, 32'hFFFF_FFFF, "R8");
    idle();
    rd(12'h100, "R8 unaligned ignored"); rd(12'h0FC, "R8 neighbour");
    rd(12'h104, "R8 neighbour");
    // R10 transfers not taken
    step(0, 1, 1, 3'd2, 12'h000, 0, 32'h0BAD_0BAD, 1, "R10");
    step(1, 0, 1, 3'd2, 12'h000, 0, 32'h0BAD_0BAD, 1, "R10");
    idle();
    step(1, 1, 1, 3'd2, 12'h000, 0, 32'h0BAD_0BAD, 0, "R10");
    idle();
    step(1, 1, 0, 3'd2, 12'h100, 0, 0, 0, "R10");
    idle();
    rd(12'h000, "R10 no write");
    idle(); idle(); idle();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge hclk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule